// File: doc/BRIEF.md
# Invalidate Range Size Encoder

This block turns one translation-invalidate request into a single launch command word for a remote translation cache. A request carries a process address-space identifier and an inclusive virtual address window, given as a start and an end. The block picks the smallest page granule from a fixed ladder (64 KiB, then 2 MiB, then 1 GiB) such that the whole window sits inside one aligned page of that size. If no granule on the ladder covers the window, it asks for an invalidate of the entire address space instead. The window is never split into several precise commands. Covering more than the window asked for is accepted, because each command has a high cost.

Alongside the command word, the block returns the start address aligned down to the chosen granule, a two-bit granule code and an error flag. The error flag is set when the end address lies below the start address. The launch word packs its fields at fixed positions; in the list below, bit 0 is the least significant bit of the 64-bit word. Every result is registered. A new request may be presented on every clock cycle.

Top module: `rie_encoder`

## Requirements
- R1: When start and end agree in every bit from bit 16 upward, the granule code is 0 (64 KiB).
- R2: When R1 does not apply but start and end agree from bit 21 upward, the granule code is 1 (2 MiB).
- R3: When neither R1 nor R2 applies but start and end agree from bit 30 upward, the granule code is 2 (1 GiB). Otherwise the granule code is 3 (whole address space).
- R4: The returned start address is the request start with its low bits cleared: 16 bits for code 0, 21 bits for code 1, and 30 bits for codes 2 and 3.
- R5: Bit 50 of the launch word, the process-scope flag, is always 1.
- R6: The address-space identifier occupies launch bits 25 and upward, with its least significant bit at bit 25.
- R7: For code 3, bit 51 (invalidate all) is 1 and the size field, bits 48:46, is 0. For codes 0, 1 and 2, bit 51 is 0 and bits 48:46 hold the size code 5, 1 or 3 respectively.
- R8: Bit 24 (suppress flush) is always 0. Every bit not named in R5 to R7 is 0.
- R9: When the end address is below the start address, the error output is 1 and the granule code is 3. Otherwise the error output is 0.
- R10: Results appear exactly one cycle after the request valid. Back-to-back requests each give their own result. The response valid is 0 in any cycle that follows a cycle with no request.
- R11: While reset is held and after it is released, before any request arrives, the response valid, start, granule, command and error outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_asid | input | ID_W | Address-space identifier |
| req_start | input | ADDR_W | First byte address of the window |
| req_end | input | ADDR_W | Last byte address of the window (inclusive) |
| rsp_vld | output | 1 | Result valid |
| rsp_start | output | ADDR_W | Start address aligned to the chosen granule |
| rsp_gran | output | 2 | Granule code: 0 = 64 KiB, 1 = 2 MiB, 2 = 1 GiB, 3 = whole address space |
| rsp_cmd | output | 64 | Launch command word |
| rsp_err | output | 1 | End address was below the start address |

## Verification
Every result of a request (aligned start, granule code, command word and error flag) is due on the first rising edge after the request is presented, and all of these results share one register stage. The bench drives inputs on the falling edge. On the next falling edge it compares the outputs against the expected values held for the request it drove on the previous falling edge, and it presents the next request in that same step. Because of this, back-to-back traffic is checked at one result per cycle. An idle step checks that the response valid has dropped.

// File: rtl/rie_pkg.sv
package rie_pkg;

  typedef enum logic [1:0] {
    GR_64K = 2'd0,
    GR_2M  = 2'd1,
    GR_1G  = 2'd2,
    GR_ALL = 2'd3
  } gran_e;

  localparam int unsigned CMD_W = 64;

  // Field positions in the launch word, derived from MSB-first numbering
  localparam int unsigned POS_ALL      = CMD_W - 1 - 12;
  localparam int unsigned POS_SCOPE    = CMD_W - 1 - 13;
  localparam int unsigned POS_SIZE_LSB = CMD_W - 1 - 17;
  localparam int unsigned POS_ASID_LSB = CMD_W - 1 - 38;
  localparam int unsigned POS_NOFLUSH  = CMD_W - 1 - 39;

endpackage

// File: rtl/rie_granule_sel.sv
module rie_granule_sel
  import rie_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SH_S   = 16,
  parameter int unsigned SH_M   = 21,
  parameter int unsigned SH_L   = 30
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output gran_e             gran_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] start_algn_o
);

  localparam int unsigned NLVL = 3;
  localparam int unsigned SH [NLVL] = '{SH_S, SH_M, SH_L};

  logic [NLVL-1:0]   lvl_eq;
  logic [ADDR_W-1:0] lvl_start [NLVL];

  // One comparator and one alignment per rung of the ladder
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam logic [ADDR_W-1:0] KEEP = ~((ADDR_W'(1) << SH[g]) - ADDR_W'(1));
    assign lvl_eq[g]    = (start_i & KEEP) == (end_i & KEEP);
    assign lvl_start[g] = start_i & KEEP;
  end

  always_comb begin
    err_o = end_i < start_i;
    if (err_o)          gran_o = GR_ALL;
    else if (lvl_eq[0]) gran_o = GR_64K;
    else if (lvl_eq[1]) gran_o = GR_2M;
    else if (lvl_eq[2]) gran_o = GR_1G;
    else                gran_o = GR_ALL;
  end

  always_comb begin
    unique case (gran_o)
      GR_64K:  start_algn_o = lvl_start[0];
      GR_2M:   start_algn_o = lvl_start[1];
      default: start_algn_o = lvl_start[2];
    endcase
  end

endmodule

// File: rtl/rie_launch_pack.sv
module rie_launch_pack
  import rie_pkg::*;
#(
  parameter int unsigned ID_W     = 20,
  parameter int unsigned CODE_W   = 3,
  parameter logic [CODE_W-1:0] CODE_64K = 3'd5,
  parameter logic [CODE_W-1:0] CODE_2M  = 3'd1,
  parameter logic [CODE_W-1:0] CODE_1G  = 3'd3
) (
  input  logic [ID_W-1:0]  asid_i,
  input  gran_e            gran_i,
  output logic [CMD_W-1:0] cmd_o
);

  // The identifier must stay below the size field; the size field below bit 50
  localparam int unsigned ASID_TOP = POS_ASID_LSB + ID_W;
  localparam int unsigned SIZE_TOP = POS_SIZE_LSB + CODE_W;

  logic [CODE_W-1:0] size_code;

  always_comb begin
    unique case (gran_i)
      GR_64K:  size_code = CODE_64K;
      GR_2M:   size_code = CODE_2M;
      GR_1G:   size_code = CODE_1G;
      default: size_code = '0;
    endcase
  end

  always_comb begin
    cmd_o = '0;
    cmd_o[POS_SCOPE] = 1'b1;
    cmd_o[POS_ASID_LSB +: ID_W] = asid_i;
    if (gran_i == GR_ALL) cmd_o[POS_ALL] = 1'b1;
    else                  cmd_o[POS_SIZE_LSB +: CODE_W] = size_code;
    cmd_o[POS_NOFLUSH] = 1'b0;
  end

  always_comb begin
    assert (ASID_TOP <= POS_SIZE_LSB && SIZE_TOP <= POS_SCOPE)
      else $error("a_r6_field_overlap: launch fields overlap");
  end

endmodule

// File: rtl/rie_encoder.sv
module rie_encoder
  import rie_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ID_W   = 20,
  parameter int unsigned SH_S   = 16,
  parameter int unsigned SH_M   = 21,
  parameter int unsigned SH_L   = 30,
  parameter int unsigned CODE_W = 3,
  parameter logic [CODE_W-1:0] CODE_64K = 3'd5,
  parameter logic [CODE_W-1:0] CODE_2M  = 3'd1,
  parameter logic [CODE_W-1:0] CODE_1G  = 3'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [ID_W-1:0]   req_asid,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  output logic              rsp_vld,
  output logic [ADDR_W-1:0] rsp_start,
  output logic [1:0]        rsp_gran,
  output logic [63:0]       rsp_cmd,
  output logic              rsp_err
);

  gran_e             sel_gran;
  logic              sel_err;
  logic [ADDR_W-1:0] sel_start;
  logic [CMD_W-1:0]  pk_cmd;

  rie_granule_sel #(
    .ADDR_W(ADDR_W), .SH_S(SH_S), .SH_M(SH_M), .SH_L(SH_L)
  ) u_sel (
    .start_i     (req_start),
    .end_i       (req_end),
    .gran_o      (sel_gran),
    .err_o       (sel_err),
    .start_algn_o(sel_start)
  );

  rie_launch_pack #(
    .ID_W(ID_W), .CODE_W(CODE_W),
    .CODE_64K(CODE_64K), .CODE_2M(CODE_2M), .CODE_1G(CODE_1G)
  ) u_pack (
    .asid_i(req_asid),
    .gran_i(sel_gran),
    .cmd_o (pk_cmd)
  );

  // Single output stage; payload only loads on a request
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld   <= 1'b0;
      rsp_start <= '0;
      rsp_gran  <= '0;
      rsp_cmd   <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_start <= sel_start;
        rsp_gran  <= sel_gran;
        rsp_cmd   <= pk_cmd;
        rsp_err   <= sel_err;
      end
    end
  end

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);
  a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld);
  a_r5_scope_set: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> rsp_cmd[POS_SCOPE]);
  a_r8_flush_kept: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> !rsp_cmd[POS_NOFLUSH]);
  a_r7_all_no_size: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && rsp_gran == 2'd3) |->
      (rsp_cmd[POS_ALL] && rsp_cmd[POS_SIZE_LSB +: CODE_W] == '0));
  a_r7_range_no_all: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && rsp_gran != 2'd3) |->
      (!rsp_cmd[POS_ALL] && rsp_cmd[POS_SIZE_LSB +: CODE_W] != '0));
  a_r9_err_whole: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && rsp_err) |-> rsp_gran == 2'd3);
  a_r4_low_clear: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> rsp_start[SH_S-1:0] == '0);
  a_r6_asid_path: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_cmd[POS_ASID_LSB +: ID_W] == $past(req_asid));

endmodule

// File: tb/rie_encoder_tb_top.sv
module rie_encoder_tb_top;

  localparam int ADDR_W = 64;
  localparam int ID_W   = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_vld = 1'b0;
  logic [ID_W-1:0]   req_asid = '0;
  logic [ADDR_W-1:0] req_start = '0;
  logic [ADDR_W-1:0] req_end = '0;
  logic              rsp_vld;
  logic [ADDR_W-1:0] rsp_start;
  logic [1:0]        rsp_gran;
  logic [63:0]       rsp_cmd;
  logic              rsp_err;

  always #5 clk = ~clk;

  rie_encoder dut_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_asid(req_asid),
    .req_start(req_start), .req_end(req_end), .rsp_vld(rsp_vld),
    .rsp_start(rsp_start), .rsp_gran(rsp_gran), .rsp_cmd(rsp_cmd),
    .rsp_err(rsp_err)
  );

  int checks = 0;
  int errors = 0;

  logic              pend = 1'b0;
  logic [ADDR_W-1:0] e_start;
  logic [1:0]        e_gran;
  logic [63:0]       e_cmd;
  logic              e_err;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements, by division
  task automatic model(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e,
                       input logic [ID_W-1:0] a);
    logic [63:0] u64k, u2m, u1g;
    u64k = 64'd65536; u2m = 64'd2097152; u1g = 64'd1073741824;
    e_err = (e < s);
    if (e_err)                   e_gran = 2'd3;
    else if (s / u64k == e / u64k) e_gran = 2'd0;
    else if (s / u2m == e / u2m)    e_gran = 2'd1;
    else if (s / u1g == e / u1g)    e_gran = 2'd2;
    else                         e_gran = 2'd3;
    case (e_gran)
      2'd0:    e_start = (s / u64k) * u64k;
      2'd1:    e_start = (s / u2m) * u2m;
      default: e_start = (s / u1g) * u1g;
    endcase
    e_cmd = 64'd1 << 50;
    e_cmd = e_cmd + (64'(a) * 64'd33554432);
    case (e_gran)
      2'd0:    e_cmd = e_cmd + (64'd5 << 46);
      2'd1:    e_cmd = e_cmd + (64'd1 << 46);
      2'd2:    e_cmd = e_cmd + (64'd3 << 46);
      default: e_cmd = e_cmd + (64'd1 << 51);
    endcase
  endtask

  // One falling-edge step: check the result due now, then drive the next input
  task automatic step(input logic v, input logic [ADDR_W-1:0] s,
                      input logic [ADDR_W-1:0] e, input logic [ID_W-1:0] a);
    @(negedge clk);
    if (pend) begin
      chk("R10 rsp_vld", 64'(rsp_vld), 64'd1);
      chk("R1/R2/R3 rsp_gran", 64'(rsp_gran), 64'(e_gran));
      chk("R4 rsp_start", rsp_start, e_start);
      chk("R5/R6/R7/R8 rsp_cmd", rsp_cmd, e_cmd);
      chk("R9 rsp_err", 64'(rsp_err), 64'(e_err));
    end else begin
      chk("R10 idle rsp_vld", 64'(rsp_vld), 64'd0);
    end
    req_vld = v; req_start = s; req_end = e; req_asid = a;
    pend = v;
    if (v) model(s, e, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] lens [10];
    lens = '{64'd0, 64'd1, 64'hFFFF, 64'h10000, 64'h1FFFFF, 64'h200000,
             64'h3FFFFFFF, 64'h40000000, 64'h80000000, 64'hFFFF_FFFF_FFFF};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset rsp_vld", 64'(rsp_vld), 64'd0);
    chk("R11 reset rsp_cmd", rsp_cmd, 64'd0);
    chk("R11 reset rsp_start", rsp_start, 64'd0);
    chk("R11 reset rsp_gran", 64'(rsp_gran), 64'd0);
    chk("R11 reset rsp_err", 64'(rsp_err), 64'd0);
    rst = 1'b0;
    step(1'b0, '0, '0, '0);
    step(1'b0, '0, '0, '0);

    // Boundary cases: granule edges and full span
    step(1'b1, 64'hFFFF, 64'hFFFF, 20'h1);           // R1
    step(1'b1, 64'hFFFF, 64'h10000, 20'h2);          // R2
    step(1'b1, 64'h1FFFFF, 64'h200000, 20'h3);       // R3 1G
    step(1'b1, 64'h3FFFFFFF, 64'h40000000, 20'hFFFFF); // R3 whole
    step(1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 20'h0); // R3 whole
    step(1'b0, '0, '0, '0);
    step(1'b1, 64'h5000_0000, 64'h4FFF_FFFF, 20'hABCDE); // R9
    step(1'b1, 64'h1, 64'h0, 20'h12345);                 // R9
    step(1'b1, 64'h1234_5678, 64'h1234_5678, 20'h0);     // R9 equal not error

    // Sweep: many starts, ladder of lengths, back to back
    for (int k = 0; k < 48; k++) begin
      for (int j = 0; j < 10; j++) begin
        logic [63:0] s;
        s = (64'(k) * 64'h0000_0000_3A5C_7E1F) ^ (64'(k) << 33) ^ (64'(j) << 13);
        step(1'b1, s, s + lens[j], 20'(k * 37 + j * 1021));
      end
      if (k % 8 == 0) begin
        step(1'b1, 64'(k) << 20, (64'(k) << 20) - 64'd1, 20'(k)); // R9
        step(1'b0, '0, '0, '0);
      end
    end
    step(1'b0, '0, '0, '0);
    step(1'b0, '0, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule